// File: doc/BRIEF.md
# UART Transmit Framer

This block turns one byte per request into an asynchronous serial frame on a single transmit line. It is meant to sit behind a transmit FIFO and a baud-rate divisor. The divisor supplies a single-cycle enable at sixteen times the bit rate. The FIFO side presents a byte with a valid/ready handshake. A line-format control byte, held steady by the surrounding register logic, selects the character length (5 to 8 bits), whether a parity bit is sent and how it is formed, and the number of stop bits. It also sets a break condition, which holds the line low.

A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. Each bit lasts sixteen enable pulses. The character length, stop and parity settings and the data byte are captured when the byte is accepted, so later changes to them do not affect the frame already in flight. The break bit is the exception: it acts on the line in the same cycle it changes and is never captured. While break is set, the framer keeps counting, so the frame still ends on time.

Top module: `uart_tx_framer`

## Requirements
- R1: Reset state and idle state: while no frame is in progress and break is clear, `txd_o` is 1, `busy_o` is 0 and `ready_o` is 1.
- R2: A byte is accepted on a rising clock edge where `valid_i` and `ready_o` are both 1. From the next cycle on, `busy_o` is 1 and `ready_o` is 0, and the line carries a start bit (0) for 16 tick pulses. `valid_i` has no effect while `busy_o` is 1.
- R3: Format bits [1:0] select the character length: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits. The data bits follow the start bit least significant first, each lasting 16 tick pulses, and data bits above the selected length are not sent.
- R4: With format bit [3] at 0, no parity bit is sent, and the stop period follows the last data bit directly.
- R5: With format bit [3] at 1 and bit [5] at 0, a parity bit of 16 tick pulses follows the data. With bit [4] at 0, the count of ones over the sent data bits plus the parity bit is odd. With bit [4] at 1, that count is even.
- R6: With format bits [3] and [5] both at 1, the parity bit is a constant: 1 when bit [4] is 0, and 0 when bit [4] is 1.
- R7: The stop period is high. Its length is 16 tick pulses when format bit [2] is 0. When bit [2] is 1, it is 24 tick pulses for a 5-bit character and 32 tick pulses for 6, 7 or 8-bit characters.
- R8: While format bit [6] is 1, `txd_o` is 0 in the same cycle, whether the block is idle or in any part of a frame. Frame timing carries on unchanged, and the line returns to its normal value in the cycle the bit clears.
- R9: Changes to `data_i` or to format bits [5:0] after a byte has been accepted do not alter the frame in progress.
- R10: Format bit [7] has no effect on the line, the timing or the handshake.
- R11: Frame time advances only on cycles where `tick16_i` is 1. `busy_o` falls, and `ready_o` rises, on the cycle after the clock edge that counts the last stop-period tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16_i | input | 1 | Single-cycle enable at 16 times the bit rate |
| data_i | input | 8 | Byte to send, captured on acceptance |
| valid_i | input | 1 | A byte is offered on `data_i` |
| ready_o | output | 1 | The framer can accept a byte this cycle |
| line_fmt_i | input | 8 | Line-format control: [1:0] length, [2] long stop, [3] parity on, [4] parity type, [5] forced parity, [6] break, [7] unused |
| txd_o | output | 1 | Serial transmit line, idles high |
| busy_o | output | 1 | A frame is in progress |

## Verification
The assertions assume that the break bit is driven from a register and changes only between clock edges, because the line follows it combinationally. They also assume the tick enable is a clean single-cycle strobe. The bench drives every input one nanosecond after a rising edge, so each input is steady for most of the cycle. It runs the tick enable at several fixed spacings, including one on every cycle. The bench raises and drops break both in idle and partway through frames, and it rewrites the data and the other format bits while a frame is in flight. This shows that only the values captured at acceptance shape the frame.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the UART transmit framer.
// Assumes the control-byte field positions listed in the brief.
package uart_tx_pkg;

    // Which part of the frame is currently on the line.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } tx_phase_e;

    // Framing fields captured at the start of a character (break excluded).
    typedef struct packed {
        logic       par_force;
        logic       par_even;
        logic       par_on;
        logic       stop_long;
        logic [1:0] len_code;
    } frame_fmt_t;

    // Unpack the framing part of the control byte (bits 5..0).
    function automatic frame_fmt_t unpack_fmt(input logic [5:0] raw);
        frame_fmt_t f;
        f.len_code  = raw[1:0];
        f.stop_long = raw[2];
        f.par_on    = raw[3];
        f.par_even  = raw[4];
        f.par_force = raw[5];
        return f;
    endfunction

    // Number of data bits for a length code: 5 + code.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/tx_tick_counter.sv
`timescale 1ns/1ps
// Counts tick enables within one bit period and flags the last one.
// Assumes limit_i >= 1 and that limit_i stays steady while run_i is high.
module tx_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    // The period ends on the tick that brings the count to limit.
    assign wrap_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

    // Advance on each tick, restart at period end or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tx_parity_calc.sv
`timescale 1ns/1ps
// Forms the parity bit for the character being accepted.
// Only the data bits selected by the length code take part.
module tx_parity_calc
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  frame_fmt_t        fmt_i,
    output logic              par_o
);

    localparam int LEN_W = 4;

    logic [LEN_W-1:0]  nbits;
    logic [DATA_W-1:0] sent_bits;
    logic              xor_sent;

    assign nbits = char_bits(fmt_i.len_code);

    // Mask off data bits above the selected length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign sent_bits[i] = data_i[i] & (LEN_W'(i) < nbits);
    end

    assign xor_sent = ^sent_bits;

    // Forced parity is the inverse of the type bit, else odd or even.
    always_comb begin
        if (fmt_i.par_force) begin
            par_o = ~fmt_i.par_even;
        end else if (fmt_i.par_even) begin
            par_o = xor_sent;
        end else begin
            par_o = ~xor_sent;
        end
    end

endmodule

// File: rtl/tx_frame_seq.sv
`timescale 1ns/1ps
// Steps one character through start, data, parity and stop phases.
// Assumes start_i only pulses while idle; data and format are captured then.
module tx_frame_seq
    import uart_tx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  frame_fmt_t        fmt_i,
    input  logic              par_i,
    output logic              line_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(2 * OSR + 1);
    localparam int BL_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(OSR);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OSR + OSR / 2);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OSR);

    tx_phase_e         phase_q;
    logic [DATA_W-1:0] shift_q;
    logic [BL_W-1:0]   left_q;
    frame_fmt_t        fmt_q;
    logic              par_q;
    logic [CNT_W-1:0]  limit;
    logic              wrap;
    logic [3:0]        nbits_in;

    assign busy_o   = (phase_q != PH_IDLE);
    assign nbits_in = char_bits(fmt_i.len_code) - 4'd1;

    // Pick the period length of the current phase.
    always_comb begin
        if (phase_q == PH_STOP) begin
            if (!fmt_q.stop_long) begin
                limit = LIM_ONE;
            end else if (fmt_q.len_code == 2'b00) begin
                limit = LIM_HALF;
            end else begin
                limit = LIM_TWO;
            end
        end else begin
            limit = LIM_ONE;
        end
    end

    tx_tick_counter #(
        .CNT_W (CNT_W)
    ) tick_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (busy_o),
        .tick_i  (tick_i),
        .limit_i (limit),
        .wrap_o  (wrap)
    );

    // Phase sequencing and capture of the character at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            shift_q <= '0;
            left_q  <= '0;
            fmt_q   <= '0;
            par_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_START;
                        shift_q <= data_i;
                        fmt_q   <= fmt_i;
                        par_q   <= par_i;
                        left_q  <= BL_W'(nbits_in);
                    end
                end
                PH_START: begin
                    if (wrap) phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (wrap) begin
                        shift_q <= shift_q >> 1;
                        if (left_q == '0) begin
                            phase_q <= fmt_q.par_on ? PH_PARITY : PH_STOP;
                        end else begin
                            left_q <= left_q - BL_W'(1);
                        end
                    end
                end
                PH_PARITY: begin
                    if (wrap) phase_q <= PH_STOP;
                end
                PH_STOP: begin
                    if (wrap) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Line level for each phase; idle and stop are high.
    always_comb begin
        unique case (phase_q)
            PH_START:  line_o = 1'b0;
            PH_DATA:   line_o = shift_q[0];
            PH_PARITY: line_o = par_q;
            default:   line_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
// UART transmit framer: one byte per handshake becomes one serial frame.
// Assumes tick16_i is a single-cycle strobe and line_fmt_i comes from a register.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic [7:0]        line_fmt_i,
    output logic              txd_o,
    output logic              busy_o
);

    localparam int BRK_BIT = 6;

    frame_fmt_t fmt_now;
    logic       par_bit;
    logic       start;
    logic       line;
    logic       unused_fmt_hi;

    assign fmt_now       = unpack_fmt(line_fmt_i[5:0]);
    assign unused_fmt_hi = line_fmt_i[7];
    assign ready_o       = ~busy_o;
    assign start         = valid_i & ready_o;

    tx_parity_calc #(
        .DATA_W (DATA_W)
    ) par_i (
        .data_i (data_i),
        .fmt_i  (fmt_now),
        .par_o  (par_bit)
    );

    tx_frame_seq #(
        .OSR    (OSR),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick16_i),
        .start_i (start),
        .data_i  (data_i),
        .fmt_i   (fmt_now),
        .par_i   (par_bit),
        .line_o  (line),
        .busy_o  (busy_o)
    );

    // Break pulls the line low at once, without touching frame timing.
    assign txd_o = line & ~line_fmt_i[BRK_BIT];

endmodule

// File: rtl/uart_tx_framer_chk.sv
`timescale 1ns/1ps
// Property checker for the UART transmit framer, attached by bind.
module uart_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick16_i,
    input logic       valid_i,
    input logic       ready_o,
    input logic [7:0] line_fmt_i,
    input logic       txd_o,
    input logic       busy_o
);

    // R2: acceptance starts a frame and closes the handshake.
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ready_o |=> busy_o && !ready_o);

    // R2: the first cycle of a frame carries the start bit.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) && !line_fmt_i[6] |-> !txd_o);

    // R1: an idle line without break is high.
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !line_fmt_i[6] |-> txd_o);

    // R8: break holds the line low.
    a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        line_fmt_i[6] |-> !txd_o);

    // R7: the cycle before a frame ends is in the high stop period.
    a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) && !$past(line_fmt_i[6]) |-> $past(txd_o));

    // R11: a frame cannot end on a cycle without a tick.
    a_r11_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tick16_i |=> busy_o);

    // R11: without a tick the line holds its level unless break moves it.
    a_r11_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tick16_i && !line_fmt_i[6] |=> line_fmt_i[6] || $stable(txd_o));

endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16_i   (tick16_i),
    .valid_i    (valid_i),
    .ready_o    (ready_o),
    .line_fmt_i (line_fmt_i),
    .txd_o      (txd_o),
    .busy_o     (busy_o)
);

// File: tb/uart_tx_framer_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural frame model (segment queue) compared on every clock.
module uart_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       valid = 1'b0;
    logic [7:0] data = 8'h00;
    logic [7:0] fmt = 8'h00;
    logic       txd, busy, ready;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_period = 2;
    int tick_cnt = 0;
    bit done = 0;

    typedef struct {
        bit    lvl;
        int    ticks;
        string tag;
    } seg_t;

    seg_t  q[$];
    bit    m_busy = 0;
    int    m_rem = 0;
    string frame_tag = "R3";

    uart_tx_framer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16_i   (tick16),
        .data_i     (data),
        .valid_i    (valid),
        .ready_o    (ready),
        .line_fmt_i (fmt),
        .txd_o      (txd),
        .busy_o     (busy)
    );

    always #2.5 clk = ~clk;

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Build the expected segment list of one frame from the requirements.
    task automatic build(input logic [7:0] d, input logic [7:0] f);
        int n;
        int ones;
        bit p;
        seg_t s;
        n = 5 + int'(f[1:0]);
        s.lvl = 0; s.ticks = 16; s.tag = "R2"; q.push_back(s);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            s.lvl = d[i]; s.ticks = 16; s.tag = "R3"; q.push_back(s);
            ones += int'(d[i]);
        end
        if (f[3]) begin
            if (f[5]) begin
                p = ~f[4]; s.tag = "R6";
            end else begin
                p = f[4] ? (ones % 2 == 1) : (ones % 2 == 0); s.tag = "R5";
            end
            s.lvl = p; s.ticks = 16; q.push_back(s);
        end
        s.lvl = 1;
        s.ticks = !f[2] ? 16 : (n == 5 ? 24 : 32);
        s.tag = f[3] ? "R7" : "R4/R7";
        q.push_back(s);
    endtask

    // Tick enable generator, driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        tick_cnt++;
        tick16 = (tick_cnt % tick_period) == 0;
    end

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete();
            m_busy = 0;
        end else if (m_busy) begin
            if (tick16) begin
                m_rem--;
                if (m_rem == 0) begin
                    void'(q.pop_front());
                    if (q.size() == 0) m_busy = 0;
                    else m_rem = q[0].ticks;
                end
            end
        end else if (valid) begin
            build(data, fmt);
            m_busy = 1;
            m_rem = q[0].ticks;
        end
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog act=%0d exp=<150000 cycles", cyc);
            finish_run();
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            logic  exp_txd;
            string tag;
            if (fmt[6]) begin
                exp_txd = 0; tag = "R8";
            end else if (m_busy) begin
                exp_txd = q[0].lvl; tag = {q[0].tag, "/", frame_tag};
            end else begin
                exp_txd = 1; tag = "R1";
            end
            check_bit(tag, txd, exp_txd);
            check_bit("R11 busy", busy, m_busy);
            check_bit("R2 ready", ready, !m_busy);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    task automatic start_frame(input logic [7:0] d, input logic [7:0] f);
        while (!ready) step();
        data = d;
        fmt = f;
        valid = 1;
        step();
        valid = 0;
        data = ~d;
        check_bit("R2 accept busy", busy, 1'b1);
        check_bit("R2 accept ready", ready, 1'b0);
    endtask

    task automatic send(input logic [7:0] d, input logic [7:0] f);
        start_frame(d, f);
        wait_idle();
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1;
        step();
        // R1: state after reset
        check_bit("R1 txd", txd, 1'b1);
        check_bit("R1 busy", busy, 1'b0);
        check_bit("R1 ready", ready, 1'b1);

        // R3, R4, R5, R6, R7: all lengths, stop selections and parity modes
        for (int len = 0; len < 4; len++) begin
            for (int st = 0; st < 2; st++) begin
                for (int pm = 0; pm < 5; pm++) begin
                    logic [7:0] f;
                    f = {2'b00, 1'(pm >= 3), 1'(pm == 2 || pm == 4),
                         1'(pm != 0), 1'(st), 2'(len)};
                    frame_tag = "R3";
                    send(8'(8'hA5 ^ (len * 40 + st * 17 + pm * 53)), f);
                end
            end
        end

        // R10: the top format bit has no effect
        frame_tag = "R10";
        send(8'h3C, 8'h80 | 8'h0F);
        send(8'hC3, 8'h80 | 8'h28);

        // R9: data and format rewritten mid-frame, valid held while busy
        frame_tag = "R9";
        start_frame(8'h96, 8'h1B);
        repeat (30) step();
        data = 8'h5A;
        fmt = 8'h24;
        valid = 1;
        repeat (60) step();
        valid = 0;
        wait_idle();
        fmt = 8'h00;

        // R8: break during a frame, then in idle
        frame_tag = "R8";
        start_frame(8'hE7, 8'h0B);
        repeat (50) step();
        fmt = 8'h4B;
        repeat (40) step();
        fmt = 8'h0B;
        wait_idle();
        fmt = 8'h40;
        repeat (10) step();
        check_bit("R8 idle break", txd, 1'b0);
        fmt = 8'h00;
        step();
        check_bit("R1 after break", txd, 1'b1);

        // R11: tick every cycle and sparse ticks
        frame_tag = "R11";
        tick_period = 1;
        send(8'h81, 8'h1F);
        send(8'h7E, 8'h04);
        tick_period = 5;
        send(8'h55, 8'h3A);
        repeat (5) step();
        finish_run();
    end

endmodule